// File: doc/BRIEF.md
# Fractional-Rate PWM Generator with Deferred Update

This block drives one pulse-width-modulated output from a 16-bit phase accumulator. Each clock the accumulator adds an 8.8 fixed-point step, so the output frequency is the clock frequency times the step divided by 256. A fraction below one stretches the period beyond 256 clocks, and a fraction above one shortens it. The duty cycle comes from an 8-bit threshold compared against the top byte of the accumulator.

Software reaches the block through a small memory-mapped port: address, write strobe, write data and combinational read data. A control word at byte offset 0x000 holds the enable bit, the update-request bit and three staged fields. Writing the fields alone changes nothing at the output. Setting the update bit asks the hardware to copy the staged fields into the active set at the next period boundary, and the hardware clears the bit in the same cycle. While the block is disabled there is no boundary to wait for, so the copy and the clear happen at once. A write of the key value 3 to byte offset 0x804 zeroes the whole block.

Top module: `pwm_frac_gen`

## Requirements
- R1: After rst_ni is released, the control word reads 0x00000000 and pwm_o is 0.
- R2: The control word at offset 0x000 maps the threshold to bits 7:0, the whole part of the step to bits 15:8, the fraction of the step to bits 23:16, the update request to bit 30 and the enable to bit 31. Bits 29:24 are discarded on write and read as 0. Reads return the staged fields and the live update and enable bits.
- R3: While enabled, the accumulator adds {bits 15:8, bits 23:16} of the active set on every clock and wraps modulo 65536. The period is therefore 65536 / step clocks.
- R4: pwm_o is 1 while enabled and the accumulator's bits 15:8 are at or above the active threshold. A threshold of 0 keeps the output high on every cycle. With a step of 1.0 the output is high for 256 − threshold cycles of every 256.
- R5: While the enable is 0, pwm_o is 0 and the accumulator holds its value. When the block is enabled again, counting resumes from the held phase.
- R6: When the update bit is set while enabled, the output keeps the old active settings and bit 30 reads 1 until the accumulator wraps. In the wrap cycle the staged fields become active and bit 30 clears.
- R7: When the update bit is set while the enable is 0, the staged fields become active and bit 30 clears on the next clock edge.
- R8: Writing 3 to offset 0x804 clears the control word, the active settings and the accumulator, effective in the next cycle. Any other value written there has no effect.
- R9: A control write with bit 30 clear changes only the staged fields. The output keeps running on the active settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register port |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is an update request that is still waiting for a period boundary while the old settings keep driving the output. The bench builds a known phase by hand. It clears the accumulator with the reset key, commits settings while the block is disabled, enables it, and then counts clocks through a disable and re-enable. From that count it knows exactly how many edges remain before the wrap, and it samples bit 30 one cycle before and one cycle after that edge. It then checks the output against the new threshold a few cycles later.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned UPD_BIT = 30;

  // packed order matches control-word bits 23:0
  typedef struct packed {
    logic [FIELD_W-1:0] frac;
    logic [FIELD_W-1:0] whole;
    logic [FIELD_W-1:0] thresh;
  } pwm_cfg_t;

  localparam int unsigned CFG_W = $bits(pwm_cfg_t);
  localparam int unsigned ACC_W = 2 * FIELD_W;
endpackage

// File: rtl/pwm_frac_regs.sv
module pwm_frac_regs
  import pwm_frac_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] RST_OFS  = 'h804,
  parameter logic [DATA_W-1:0] RST_KEY  = 'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] rd_data_o,
  output pwm_cfg_t          cfg_o,
  output logic              en_o,
  output logic              upd_o,
  output logic              soft_rst_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_W - 2;

  logic     ctrl_wr;
  pwm_cfg_t cfg_q;
  logic     en_q, upd_q;

  assign ctrl_wr    = wr_en_i && (addr_i == CTRL_OFS);
  assign soft_rst_o = wr_en_i && (addr_i == RST_OFS) && (wr_data_i == RST_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
      upd_q <= 1'b0;
    end else if (soft_rst_o) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
      upd_q <= 1'b0;
    end else if (ctrl_wr) begin
      cfg_q <= pwm_cfg_t'(wr_data_i[CFG_W-1:0]);
      en_q  <= wr_data_i[EN_BIT];
      upd_q <= wr_data_i[UPD_BIT];
    end else if (commit_i) begin
      upd_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == CTRL_OFS) rd_data_o = {en_q, upd_q, {PAD_W{1'b0}}, cfg_q};
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;
  assign upd_o = upd_q;

  p_soft_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (cfg_q == '0) && !en_q && !upd_q)
    else $error("soft reset did not clear control word");

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[UPD_BIT-1:CFG_W] == '0)
    else $error("reserved read bits nonzero");
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned PH_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o  = en_i && sum[ACC_W];
  assign phase_o = acc_q[ACC_W-1 -: PH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= sum[ACC_W-1:0];
  end

  p_hold_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_q))
    else $error("accumulator moved while disabled");

  p_clear_acc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0))
    else $error("accumulator not cleared");
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int unsigned PH_W = 8
) (
  input  logic            en_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [PH_W-1:0] thresh_i,
  output logic            pwm_o
);
  assign pwm_o = en_i && (phase_i >= thresh_i);
endmodule

// File: rtl/pwm_frac_gen.sv
module pwm_frac_gen
  import pwm_frac_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] RST_OFS  = 'h804,
  parameter logic [DATA_W-1:0] RST_KEY  = 'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pwm_o
);
  pwm_cfg_t         stg_cfg, act_q;
  logic             en, upd, soft_rst, wrap, commit;
  logic [FIELD_W-1:0] phase;

  assign commit = upd && (!en || wrap);

  pwm_frac_regs #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .RST_OFS(RST_OFS), .RST_KEY(RST_KEY)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i,
    .commit_i(commit), .rd_data_o, .cfg_o(stg_cfg),
    .en_o(en), .upd_o(upd), .soft_rst_o(soft_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       act_q <= '0;
    else if (soft_rst) act_q <= '0;
    else if (commit)   act_q <= stg_cfg;
  end

  pwm_phase_acc #(.ACC_W(ACC_W), .PH_W(FIELD_W)) i_acc (
    .clk_i, .rst_ni, .clr_i(soft_rst), .en_i(en),
    .inc_i({act_q.whole, act_q.frac}), .phase_o(phase), .wrap_o(wrap)
  );

  pwm_cmp #(.PH_W(FIELD_W)) i_cmp (
    .en_i(en), .phase_i(phase), .thresh_i(act_q.thresh), .pwm_o
  );

  p_active_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> ($past(upd) || $past(soft_rst)))
    else $error("active settings changed without update");

  p_pending_until_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && en && !wrap && !wr_en_i) |=> upd)
    else $error("update cleared before period boundary");

  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !en && !wr_en_i) |=> !upd)
    else $error("update stalled while disabled");

  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm_o)
    else $error("output active while disabled");
endmodule

// File: tb/test_pwm_frac_gen.sv
module test_pwm_frac_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // threshold, whole, frac, cycles counted, expected high cycles
  localparam int unsigned TV [NV][5] = '{
    '{8'h80, 8'h01, 8'h00, 512, 256},
    '{8'h00, 8'h01, 8'h00, 256, 256},
    '{8'hC0, 8'h02, 8'h00, 256,  64},
    '{8'h40, 8'h00, 8'h80, 512, 384},
    '{8'hFF, 8'h01, 8'h00, 256,   1},
    '{8'h10, 8'h04, 8'h00, 128, 120}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_frac_gen i_pwm_frac_gen (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // callers stand at a negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    addr = 12'h000; #1; d = rd_data;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      c += int'(pwm);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    run(3);
    rst_n = 1'b1;
    run(1);
    rd(v); chk("R1 ctrl after reset", v, 32'h0);
    chk("R1 pwm after reset", {31'b0, pwm}, 32'h0);

    // vector table: R3 period and R4 duty
    for (int k = 0; k < NV; k++) begin
      logic [31:0] f;
      f = {8'h00, TV[k][2][7:0], TV[k][1][7:0], TV[k][0][7:0]};
      wr(12'h804, 32'd3);
      wr(12'h000, f | 32'h4000_0000);
      wr(12'h000, f | 32'h8000_0000);
      count_high(int'(TV[k][3]), c);
      chk($sformatf("R3 R4 vector %0d high count", k), c, TV[k][4]);
    end

    // R2 field map and reserved bits
    wr(12'h804, 32'd3);
    wr(12'h000, 32'h3F12_3456);
    rd(v); chk("R2 reserved bits dropped", v, 32'h0012_3456);
    wr(12'h000, 32'hC012_3456);
    rd(v); chk("R2 enable and update readback", v, 32'hC012_3456);

    // R7 update while disabled
    wr(12'h804, 32'd3);
    wr(12'h000, 32'h4000_0100);
    rd(v); chk("R7 update set", v, 32'h4000_0100);
    run(1);
    rd(v); chk("R7 update cleared at once", v, 32'h0000_0100);
    wr(12'h000, 32'h8000_0100);
    chk("R4 zero threshold high", {31'b0, pwm}, 32'h1);

    // R8 reset key
    wr(12'h804, 32'd1);
    chk("R8 wrong key pwm", {31'b0, pwm}, 32'h1);
    rd(v); chk("R8 wrong key ctrl", v, 32'h8000_0100);
    wr(12'h804, 32'd3);
    chk("R8 key pwm", {31'b0, pwm}, 32'h0);
    rd(v); chk("R8 key ctrl", v, 32'h0);

    // R5 hold while disabled, resume from held phase
    wr(12'h000, 32'h4000_0180);
    wr(12'h000, 32'h8000_0180);
    run(100);
    wr(12'h000, 32'h0000_0180);
    count_high(500, c);
    chk("R5 idle output", c, 0);
    wr(12'h000, 32'h8000_0180);
    chk("R5 resume phase 101", {31'b0, pwm}, 32'h0);
    run(26);
    chk("R5 resume phase 127", {31'b0, pwm}, 32'h0);
    run(1);
    chk("R5 resume phase 128", {31'b0, pwm}, 32'h1);

    // R9 staged write without update
    wr(12'h000, 32'h8000_0110);
    count_high(256, c);
    chk("R9 staged only", c, 128);

    // R6 deferred commit (phase 129 here, 130 after write)
    wr(12'h000, 32'hC000_0110);
    rd(v); chk("R6 update pending", {31'b0, v[30]}, 32'h1);
    run(125);
    rd(v); chk("R6 pending before wrap", {31'b0, v[30]}, 32'h1);
    run(1);
    rd(v); chk("R6 cleared at wrap", {31'b0, v[30]}, 32'h0);
    run(16);
    chk("R6 new threshold live", {31'b0, pwm}, 32'h1);
    count_high(256, c);
    chk("R6 new duty", c, 240);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule